// File: doc/BRIEF.md
# Configurable Asynchronous Serial Receiver

This block recovers characters from an asynchronous serial line. It is driven by an oversampling enable, `os_tick`, that pulses sixteen times per bit period. A falling edge on the line opens a start-bit check. The receiver then samples each data bit and the optional parity bit at its centre, and checks the first stop bit. It delivers a right-aligned character with a one-cycle valid strobe, together with parity-error and framing-error flags.

The format comes from the same control field the matching transmitter uses:

- `cfg_fmt[1:0]` sets the data width: 0 means 5 bits, 1 means 6, 2 means 7, 3 means 8.
- `cfg_fmt[3]` enables parity.
- `cfg_fmt[4]` selects the parity sense.
- `cfg_fmt[5]` selects forced (stuck) parity instead of computed parity.
- `cfg_fmt[2]` is the transmitter's stop-count bit. The receiver ignores it.

The format is captured when the start bit is confirmed, so the format can change while a character is in flight without affecting that character.

The control path is one state machine with these states:

- ST_IDLE waits for a falling edge. Transition: edge seen, go to ST_START.
- ST_START counts to mid-bit. Transitions: line high at mid-bit is a glitch, go back to ST_IDLE; line still low, go to ST_DATA.
- ST_DATA takes one sample every 16 ticks. Transitions: after the last data bit, go to ST_PARITY if parity is enabled, otherwise go to ST_STOP.
- ST_PARITY takes one sample. Transition: go to ST_STOP.
- ST_STOP samples the stop bit, issues the strobe and returns to ST_IDLE.

Top module: `cfg_uart_rx`

## Requirements
- R1: `cfg_fmt[1:0]` selects 5, 6, 7 or 8 data bits (codes 0 to 3). The character is right-aligned in `rx_data`, and bits above the selected width read 0.
- R2: Data bits arrive least-significant bit first, one bit per 16 ticks, each sampled at its centre.
- R3: With `cfg_fmt[3]`=1 and `cfg_fmt[5]`=0, a parity bit follows the data. `cfg_fmt[4]`=0 expects an odd count of ones over data plus parity, and `cfg_fmt[4]`=1 expects an even count. A mismatch raises `parity_err`.
- R4: With `cfg_fmt[3]`=1 and `cfg_fmt[5]`=1, the parity bit must be 1 when `cfg_fmt[4]`=0 and 0 when `cfg_fmt[4]`=1. Otherwise `parity_err` is raised.
- R5: With `cfg_fmt[3]`=0, no parity bit is expected: the stop bit directly follows the data, and `parity_err` stays 0.
- R6: A falling edge whose line is high again at the 8th tick is discarded. No strobe results, and the next proper character is received normally.
- R7: Only the first stop bit is checked. A low sample raises `frame_err` with that character, and the receiver then waits for a new falling edge.
- R8: `rx_valid` is a single-cycle pulse. `parity_err` and `frame_err` are 0 whenever `rx_valid` is 0.
- R9: The format is captured at start-bit confirmation. A change of `cfg_fmt` later in the character has no effect on it.
- R10: After reset, `rx_valid`, `rx_data`, `parity_err` and `frame_err` are 0.
- R11: `rx_valid` rises one cycle after the tick that samples the stop bit. That tick is the (8 + 16·(1 + width + parity))-th tick after the falling edge is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| os_tick | input | 1 | Oversampling enable, 16 pulses per bit |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| cfg_fmt | input | 6 | Format: [1:0] width, [2] unused, [3] parity on, [4] parity sense, [5] forced parity |
| rx_data | output | 8 | Received character, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for a completed character |
| parity_err | output | 1 | Parity mismatch, qualified by rx_valid |
| frame_err | output | 1 | Low stop bit, qualified by rx_valid |

## Verification
The bench sets the tick to one clock in four, so a bit lasts 64 clocks. Each character's strobe is therefore due 4·(8 + 16·(1 + width + parity)) clocks after the line falls. To that figure are added two synchronizer stages, the idle-edge register, up to one tick of phase, and the output register.

Each scenario task drives the line on falling clock edges and watches `rx_valid` on falling edges. It records the cycle in which the strobe appears and requires that cycle to lie within a 12-clock window after the computed figure. It samples data and flags in that same cycle. For glitches, the task counts strobes over a full character time and expects none.

// File: rtl/cfg_uart_rx_pkg.sv
package cfg_uart_rx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } rx_state_e;

    // Captured character format
    typedef struct packed {
        logic       force_par;   // parity bit is stuck, not computed
        logic       par_sense;   // 0: odd / stuck-1, 1: even / stuck-0
        logic       par_en;      // parity bit present
        logic [1:0] wsel;        // data width code, width = 5 + code
    } rx_fmt_t;

endpackage

// File: rtl/cfg_uart_rx_sync.sv
module cfg_uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic q_out
);
    logic [STAGES-1:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= {pipe_q[STAGES-2:0], d_in};
    end

    assign q_out = pipe_q[STAGES-1];
endmodule

// File: rtl/cfg_uart_rx_parity.sv
module cfg_uart_rx_parity #(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic [1:0]        wsel,
    input  logic              par_sense,
    input  logic              force_par,
    output logic              exp_bit
);
    logic [DATA_W-1:0] keep;
    logic              ones_odd;

    // Only bits inside the selected width take part
    for (genvar i = 0; i < DATA_W; i++) begin : g_mask
        assign keep[i] = (i < 5 + int'(wsel));
    end

    assign ones_odd = ^(data & keep);

    always_comb begin
        if (force_par)      exp_bit = ~par_sense;
        else if (par_sense) exp_bit = ones_odd;      // even total
        else                exp_bit = ~ones_odd;     // odd total
    end
endmodule

// File: rtl/cfg_uart_rx.sv
module cfg_uart_rx
    import cfg_uart_rx_pkg::*;
#(
    parameter int OSR      = 16,
    parameter int DATA_W   = 8,
    parameter int SYNC_STG = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              os_tick,
    input  logic              rx_in,
    input  logic [5:0]        cfg_fmt,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              parity_err,
    output logic              frame_err
);
    localparam int CNT_W = $clog2(OSR);
    localparam int IDX_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OSR/2 - 1);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OSR - 1);

    rx_state_e         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] shift_q;
    rx_fmt_t           fmt_q;
    logic              par_bad_q;
    logic              rx_s, rx_prev_q;
    logic              at_mid, at_end, last_bit, exp_par;
    logic              unused_stop_cfg;

    assign unused_stop_cfg = cfg_fmt[2];

    cfg_uart_rx_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (rx_in),
        .q_out (rx_s)
    );

    cfg_uart_rx_parity #(.DATA_W(DATA_W)) u_par (
        .data      (shift_q),
        .wsel      (fmt_q.wsel),
        .par_sense (fmt_q.par_sense),
        .force_par (fmt_q.force_par),
        .exp_bit   (exp_par)
    );

    assign at_mid   = os_tick && (cnt_q == MID_CNT);
    assign at_end   = os_tick && (cnt_q == LAST_CNT);
    assign last_bit = (idx_q == IDX_W'(4 + int'(fmt_q.wsel)));

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (!rx_s && rx_prev_q) state_d = ST_START;
            ST_START:  if (at_mid) state_d = rx_s ? ST_IDLE : ST_DATA;
            ST_DATA:   if (at_end && last_bit)
                           state_d = fmt_q.par_en ? ST_PARITY : ST_STOP;
            ST_PARITY: if (at_end) state_d = ST_STOP;
            ST_STOP:   if (at_end) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath: tick counter, bit index, assembly, captured format
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            idx_q     <= '0;
            shift_q   <= '0;
            fmt_q     <= '0;
            par_bad_q <= 1'b0;
            rx_prev_q <= 1'b1;
        end else begin
            rx_prev_q <= rx_s;
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                end
                ST_START: begin
                    if (at_mid) begin
                        cnt_q     <= '0;
                        idx_q     <= '0;
                        shift_q   <= '0;
                        par_bad_q <= 1'b0;
                        fmt_q     <= '{force_par: cfg_fmt[5], par_sense: cfg_fmt[4],
                                       par_en: cfg_fmt[3], wsel: cfg_fmt[1:0]};
                    end else if (os_tick) begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_DATA, ST_PARITY, ST_STOP: begin
                    if (os_tick) cnt_q <= at_end ? '0 : cnt_q + 1'b1;
                    if (state_q == ST_DATA && at_end) begin
                        shift_q[idx_q] <= rx_s;
                        idx_q          <= idx_q + 1'b1;
                    end
                    if (state_q == ST_PARITY && at_end)
                        par_bad_q <= (rx_s != exp_par);
                end
                default: cnt_q <= '0;
            endcase
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data    <= '0;
            rx_valid   <= 1'b0;
            parity_err <= 1'b0;
            frame_err  <= 1'b0;
        end else if (state_q == ST_STOP && at_end) begin
            rx_data    <= shift_q;
            rx_valid   <= 1'b1;
            parity_err <= par_bad_q;
            frame_err  <= ~rx_s;
        end else begin
            rx_valid   <= 1'b0;
            parity_err <= 1'b0;
            frame_err  <= 1'b0;
        end
    end
endmodule

// File: rtl/cfg_uart_rx_chk.sv
module cfg_uart_rx_chk
    import cfg_uart_rx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rx_valid,
    input logic              parity_err,
    input logic              frame_err,
    input logic [DATA_W-1:0] rx_data,
    input rx_state_e         state_q,
    input rx_fmt_t           fmt_q
);
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);                                        // R8

    AST_FLAGS_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_valid |-> (!parity_err && !frame_err));                     // R8

    AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && fmt_q.wsel == 2'd0) |-> (rx_data[DATA_W-1:5] == '0)); // R1

    AST_NO_PARITY_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !fmt_q.par_en) |-> !parity_err);                   // R5

    AST_FMT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_START) |=> $stable(fmt_q));                      // R9

    AST_IDLE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> (state_q == ST_IDLE));                             // R7
endmodule

bind cfg_uart_rx cfg_uart_rx_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rx_valid   (rx_valid),
    .parity_err (parity_err),
    .frame_err  (frame_err),
    .rx_data    (rx_data),
    .state_q    (state_q),
    .fmt_q      (fmt_q)
);

// File: tb/cfg_uart_rx_tb.sv
`timescale 1ns/1ps
module cfg_uart_rx_tb;
    localparam int TICK_DIV = 4;
    localparam int BIT_CLK  = 16 * TICK_DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       os_tick;
    logic       rx_in = 1'b1;
    logic [5:0] cfg_fmt = 6'b0;
    logic [7:0] rx_data;
    logic       rx_valid, parity_err, frame_err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [1:0] tdiv = '0;

    always #4 clk = ~clk;   // 125 MHz

    always_ff @(posedge clk) tdiv <= tdiv + 1'b1;
    assign os_tick = (tdiv == 2'd3);

    cfg_uart_rx u_dut (
        .clk (clk), .rst_n (rst_n), .os_tick (os_tick), .rx_in (rx_in),
        .cfg_fmt (cfg_fmt), .rx_data (rx_data), .rx_valid (rx_valid),
        .parity_err (parity_err), .frame_err (frame_err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    // Drives one character and checks strobe time, data and flags.
    // new_fmt is applied two bits after the start edge (R9 scenario).
    task automatic send_char(input string req, input logic [5:0] fmt,
                             input logic [5:0] new_fmt, input logic [7:0] val,
                             input bit flip_par, input bit stop_v);
        int  nbits, pbits, lat, seen;
        logic [7:0] keep, expd;
        logic pbit, ones;
        nbits = 5 + int'(fmt[1:0]);
        pbits = fmt[3] ? 1 : 0;
        keep  = 8'((9'd1 << nbits) - 1);
        expd  = val & keep;
        ones  = ^expd;
        if (fmt[5])      pbit = ~fmt[4];
        else if (fmt[4]) pbit = ones;
        else             pbit = ~ones;
        pbit = pbit ^ flip_par;
        lat  = TICK_DIV * (8 + 16 * (1 + nbits + pbits));
        seen = -1;
        @(negedge clk);
        cfg_fmt = fmt;
        fork
            begin
                rx_in = 1'b0;
                repeat (BIT_CLK) @(negedge clk);
                for (int i = 0; i < nbits; i++) begin
                    if (i == 1) cfg_fmt = new_fmt;
                    rx_in = val[i];
                    repeat (BIT_CLK) @(negedge clk);
                end
                if (pbits == 1) begin
                    rx_in = pbit;
                    repeat (BIT_CLK) @(negedge clk);
                end
                rx_in = stop_v;
                repeat (BIT_CLK) @(negedge clk);
                rx_in = 1'b1;
                repeat (BIT_CLK) @(negedge clk);
            end
            begin
                for (int c = 1; c <= lat + 40; c++) begin
                    @(negedge clk);
                    if (rx_valid && seen < 0) begin
                        seen = c;
                        chk({req, " data"}, int'(rx_data), int'(expd));
                        chk({req, " parity_err"}, int'(parity_err),
                            (pbits == 1 && flip_par) ? 1 : 0);
                        chk({req, " frame_err"}, int'(frame_err), stop_v ? 0 : 1);
                    end
                end
            end
        join
        // R11: strobe due lat clocks plus sync/phase/output-register slack
        chk({req, " R11 strobe in window"},
            int'(seen >= lat && seen <= lat + 12), 1);
        cfg_fmt = fmt;
    endtask

    task automatic t_reset();
        chk("R10 rx_valid", int'(rx_valid), 0);
        chk("R10 rx_data", int'(rx_data), 0);
        chk("R10 parity_err", int'(parity_err), 0);
        chk("R10 frame_err", int'(frame_err), 0);
    endtask

    task automatic t_glitch();
        int strobes = 0;
        @(negedge clk);
        rx_in = 1'b0;
        repeat (3 * TICK_DIV) @(negedge clk);
        rx_in = 1'b1;
        repeat (12 * BIT_CLK) begin
            @(negedge clk);
            if (rx_valid) strobes++;
        end
        chk("R6 glitch produces no strobe", strobes, 0);
        send_char("R6 recovery after glitch", 6'b000011, 6'b000011, 8'h3C, 0, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (BIT_CLK) @(negedge clk);
        // 8 bits, no parity, LSB-first pattern
        send_char("R2 R5 8N", 6'b000011, 6'b000011, 8'hA5, 0, 1);
        send_char("R2 R5 8N alt", 6'b000011, 6'b000011, 8'h01, 0, 1);
        // width codes 0..2, upper bits masked
        send_char("R1 5-bit", 6'b000000, 6'b000000, 8'hFF, 0, 1);
        send_char("R1 6-bit", 6'b000001, 6'b000001, 8'hEA, 0, 1);
        send_char("R1 7-bit", 6'b000010, 6'b000010, 8'hD3, 0, 1);
        // computed parity
        send_char("R3 odd ok", 6'b001011, 6'b001011, 8'h37, 0, 1);
        send_char("R3 even ok", 6'b011000, 6'b011000, 8'h15, 0, 1);
        send_char("R3 odd bad", 6'b001001, 6'b001001, 8'h2A, 1, 1);
        send_char("R3 even bad", 6'b011011, 6'b011011, 8'hC4, 1, 1);
        // forced parity
        send_char("R4 stuck-1 ok", 6'b101010, 6'b101010, 8'h55, 0, 1);
        send_char("R4 stuck-0 ok", 6'b111011, 6'b111011, 8'h80, 0, 1);
        send_char("R4 stuck-1 bad", 6'b101011, 6'b101011, 8'h0F, 1, 1);
        send_char("R4 stuck-0 bad", 6'b111000, 6'b111000, 8'h1B, 1, 1);
        // framing
        send_char("R7 low stop", 6'b000011, 6'b000011, 8'h66, 0, 0);
        send_char("R7 next after frame error", 6'b000011, 6'b000011, 8'h99, 0, 1);
        // format change mid-character
        send_char("R9 fmt change ignored", 6'b000011, 6'b111000, 8'hB7, 0, 1);
        t_glitch();
        chk("R8 no strobe when idle", int'(rx_valid), 0);
        summary();
    end
endmodule